// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general-purpose register storage for a small 32-bit load/store core that runs in one of six operating modes. Software sees sixteen architectural registers, selected by a 4-bit index. Index 15 is the program counter, index 14 is the link register and index 13 is the stack pointer. A mode input, driven from outside, decides which physical copy each index reaches. Registers 0 to 7 are never duplicated. The fast-interrupt mode swaps in its own copies of registers 8 to 14. Each of the four other exception modes swaps in its own copies of 13 and 14 only.

There are two combinational read ports and one synchronous write port. A separate write path loads the program counter. The block also holds a single current status word that every mode shares, and one saved status word for each exception mode. The saved status word of the active mode can be read and written.

Top module: `mode_regfile`

## Requirements
- R1: Indices 0 to 7 reach one shared physical set: a value written in any mode reads back unchanged in every mode.
- R2: With mode=1 (fast interrupt), indices 8 to 14 reach private copies. Writes there leave the user-mode view of 8 to 14 unchanged, and user-mode writes leave these copies unchanged.
- R3: With mode=2, 3, 4 or 5, indices 13 and 14 reach a private copy per mode, while indices 8 to 12 reach the same storage as user mode (mode=0).
- R4: Mode values 6 and 7 behave exactly as user mode for general registers and saved status.
- R5: Index 15 reads the program counter, which is also shown on pcOut. pcWrEn loads pcWrData at the clock edge. When pcWrEn and a port write to index 15 arrive in the same cycle, pcWrData wins.
- R6: Each mode 1 to 5 has its own saved status word, accessed through spsrWrEn/spsrWrData/spsrRdData. In user mode spsrRdData reads zero and spsrWrEn has no effect.
- R7: The current status word (cpsrOut) is one register shared by all modes. It changes only on cpsrWrEn.
- R8: A read of a register in the cycle it is written returns the old value. The new value appears from the following cycle.
- R9: A synchronous active-high reset clears every general register, the program counter and all status words to zero.
- R10: The two read ports select independently and can read different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Current operating mode (0 user, 1 fast interrupt, 2 IRQ, 3 supervisor, 4 abort, 5 undefined) |
| rdIdxA | input | 4 | Read port A index |
| rdDataA | output | 32 | Read port A data (combinational) |
| rdIdxB | input | 4 | Read port B index |
| rdDataB | output | 32 | Read port B data (combinational) |
| wrEn | input | 1 | Register write enable |
| wrIdx | input | 4 | Register write index |
| wrData | input | 32 | Register write data |
| pcWrEn | input | 1 | Program counter write enable |
| pcWrData | input | 32 | Program counter write data |
| pcOut | output | 32 | Current program counter |
| spsrWrEn | input | 1 | Saved status write enable for the active mode |
| spsrWrData | input | 32 | Saved status write data |
| spsrRdData | output | 32 | Saved status word of the active mode |
| cpsrWrEn | input | 1 | Current status write enable |
| cpsrWrData | input | 32 | Current status write data |
| cpsrOut | output | 32 | Current status word |

## Verification
The read ports have zero latency: any index or mode change shows on rdDataA and rdDataB in the same cycle. Every write, whether to a register, the program counter or a status word, becomes visible one clock edge after its enable is sampled. The bench therefore drives inputs just after a falling edge and checks reads a moment later in the same low phase. A value written with enables high across one rising edge is checked at the next falling edge. The same-cycle case of R8 is checked before that rising edge, and the new value is checked after it.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int IDX_W     = 4;
  localparam int MODE_W    = 3;
  localparam int SHARED_N  = 8;             // indices 0..7
  localparam int HI_N      = 7;             // indices 8..14
  localparam int SMALL_N   = 2;             // indices 13..14
  localparam int SMALL_MODES = 4;           // IRQ, SVC, ABT, UND
  localparam int EXC_N     = SMALL_MODES + 1;
  localparam int FIQ_BASE  = SHARED_N + HI_N;
  localparam int BANK_BASE = FIQ_BASE + HI_N;
  localparam int PC_PHYS   = BANK_BASE + SMALL_N * SMALL_MODES;
  localparam int NPHYS     = PC_PHYS + 1;
  localparam int PHYS_W    = $clog2(NPHYS);
  localparam int SLOT_W    = $clog2(EXC_N);
  localparam int PC_IDX    = 15;
  localparam int SP_IDX    = 13;

  typedef enum logic [MODE_W-1:0] {
    MODE_USR = 3'd0,
    MODE_FIQ = 3'd1,
    MODE_IRQ = 3'd2,
    MODE_SVC = 3'd3,
    MODE_ABT = 3'd4,
    MODE_UND = 3'd5
  } modeT;

  typedef struct packed {
    logic [PHYS_W-1:0] physA;
    logic [PHYS_W-1:0] physB;
    logic [PHYS_W-1:0] physW;
    logic              gprWr;
    logic              pcWr;
    logic [SLOT_W-1:0] spsrSlot;
    logic              spsrValid;
    logic              spsrWr;
    logic              cpsrWr;
  } ctrlT;
endpackage

// File: rtl/rb_ctrl.sv
module rb_ctrl
  import regbank_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  input  logic [IDX_W-1:0]  rdIdxA,
  input  logic [IDX_W-1:0]  rdIdxB,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrEn,
  input  logic              pcWrEn,
  input  logic              spsrWrEn,
  input  logic              cpsrWrEn,
  output ctrlT              ctrl
);
  modeT effMode;

  always_comb begin
    if (mode <= MODE_W'(MODE_UND)) effMode = modeT'(mode);
    else                           effMode = MODE_USR;
  end

  function automatic logic [PHYS_W-1:0] mapIdx(input logic [IDX_W-1:0] idx,
                                               input modeT m);
    logic [PHYS_W-1:0] p;
    logic [PHYS_W-1:0] wideIdx;
    wideIdx = PHYS_W'(idx);
    if (idx == IDX_W'(PC_IDX)) begin
      p = PHYS_W'(PC_PHYS);
    end else if (wideIdx < PHYS_W'(SHARED_N)) begin
      p = wideIdx;
    end else if (m == MODE_FIQ) begin
      p = PHYS_W'(FIQ_BASE) + wideIdx - PHYS_W'(SHARED_N);
    end else if (m != MODE_USR && wideIdx >= PHYS_W'(SP_IDX)) begin
      p = PHYS_W'(BANK_BASE)
        + PHYS_W'(SMALL_N) * (PHYS_W'(m) - PHYS_W'(MODE_IRQ))
        + wideIdx - PHYS_W'(SP_IDX);
    end else begin
      p = wideIdx;
    end
    return p;
  endfunction

  always_comb begin
    ctrl           = '0;
    ctrl.physA     = mapIdx(rdIdxA, effMode);
    ctrl.physB     = mapIdx(rdIdxB, effMode);
    ctrl.physW     = mapIdx(wrIdx, effMode);
    ctrl.gprWr     = wrEn;
    ctrl.pcWr      = pcWrEn;
    ctrl.spsrValid = (effMode != MODE_USR);
    ctrl.spsrSlot  = ctrl.spsrValid ? SLOT_W'(effMode - MODE_FIQ) : '0;
    ctrl.spsrWr    = spsrWrEn && ctrl.spsrValid;
    ctrl.cpsrWr    = cpsrWrEn;
  end
endmodule

// File: rtl/rb_data.sv
module rb_data
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlT              ctrl,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] pcWrData,
  input  logic [DATA_W-1:0] spsrWrData,
  input  logic [DATA_W-1:0] cpsrWrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] spsrRdData,
  output logic [DATA_W-1:0] cpsrOut
);
  logic [DATA_W-1:0] gpr  [NPHYS];
  logic [DATA_W-1:0] spsr [EXC_N];
  logic [DATA_W-1:0] cpsr;

  for (genvar p = 0; p < NPHYS; p++) begin : g_gpr
    logic portHit;
    assign portHit = ctrl.gprWr && (ctrl.physW == PHYS_W'(p));
    if (p == PC_PHYS) begin : g_pc
      always_ff @(posedge clk) begin
        if (rst)            gpr[p] <= '0;
        else if (ctrl.pcWr) gpr[p] <= pcWrData;
        else if (portHit)   gpr[p] <= wrData;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)          gpr[p] <= '0;
        else if (portHit) gpr[p] <= wrData;
      end
    end
  end

  for (genvar s = 0; s < EXC_N; s++) begin : g_spsr
    always_ff @(posedge clk) begin
      if (rst)
        spsr[s] <= '0;
      else if (ctrl.spsrWr && ctrl.spsrSlot == SLOT_W'(s))
        spsr[s] <= spsrWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)              cpsr <= '0;
    else if (ctrl.cpsrWr) cpsr <= cpsrWrData;
  end

  assign rdDataA    = gpr[ctrl.physA];
  assign rdDataB    = gpr[ctrl.physB];
  assign pcOut      = gpr[PC_PHYS];
  assign spsrRdData = ctrl.spsrValid ? spsr[ctrl.spsrSlot] : '0;
  assign cpsrOut    = cpsr;
endmodule

// File: rtl/mode_regfile.sv
module mode_regfile
  import regbank_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [3:0]        rdIdxA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdIdxB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              pcWrEn,
  input  logic [DATA_W-1:0] pcWrData,
  output logic [DATA_W-1:0] pcOut,
  input  logic              spsrWrEn,
  input  logic [DATA_W-1:0] spsrWrData,
  output logic [DATA_W-1:0] spsrRdData,
  input  logic              cpsrWrEn,
  input  logic [DATA_W-1:0] cpsrWrData,
  output logic [DATA_W-1:0] cpsrOut
);
  ctrlT ctrl;

  rb_ctrl u_ctrl (
    .mode     (mode),
    .rdIdxA   (rdIdxA),
    .rdIdxB   (rdIdxB),
    .wrIdx    (wrIdx),
    .wrEn     (wrEn),
    .pcWrEn   (pcWrEn),
    .spsrWrEn (spsrWrEn),
    .cpsrWrEn (cpsrWrEn),
    .ctrl     (ctrl)
  );

  rb_data #(.DATA_W(DATA_W)) u_data (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .wrData     (wrData),
    .pcWrData   (pcWrData),
    .spsrWrData (spsrWrData),
    .cpsrWrData (cpsrWrData),
    .rdDataA    (rdDataA),
    .rdDataB    (rdDataB),
    .pcOut      (pcOut),
    .spsrRdData (spsrRdData),
    .cpsrOut    (cpsrOut)
  );
endmodule

// File: rtl/mode_regfile_chk.sv
module mode_regfile_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        mode,
  input logic [3:0]        rdIdxA,
  input logic [DATA_W-1:0] rdDataA,
  input logic [3:0]        rdIdxB,
  input logic [DATA_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [3:0]        wrIdx,
  input logic [DATA_W-1:0] wrData,
  input logic              pcWrEn,
  input logic [DATA_W-1:0] pcWrData,
  input logic [DATA_W-1:0] pcOut,
  input logic [DATA_W-1:0] spsrRdData,
  input logic              cpsrWrEn,
  input logic [DATA_W-1:0] cpsrOut
);
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pcOut == '0 && cpsrOut == '0 && spsrRdData == '0
             && rdDataA == '0 && rdDataB == '0));

  // R6
  user_spsr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd0) |-> (spsrRdData == '0));

  // R5
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    pcWrEn |=> (pcOut == $past(pcWrData)));

  // R7
  cpsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cpsrWrEn |=> $stable(cpsrOut));

  // R1
  shared_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrEn) && $past(wrIdx) < 4'd8
     && rdIdxA == $past(wrIdx)) |-> (rdDataA == $past(wrData)));

  // R8
  next_cycle_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wrEn) && $past(wrIdx) < 4'd8
     && rdIdxB == $past(wrIdx)) |-> (rdDataB == $past(wrData)));
endmodule

bind mode_regfile mode_regfile_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .rdIdxA(rdIdxA), .rdDataA(rdDataA),
  .rdIdxB(rdIdxB), .rdDataB(rdDataB), .wrEn(wrEn), .wrIdx(wrIdx),
  .wrData(wrData), .pcWrEn(pcWrEn), .pcWrData(pcWrData), .pcOut(pcOut),
  .spsrRdData(spsrRdData), .cpsrWrEn(cpsrWrEn), .cpsrOut(cpsrOut)
);

// File: tb/mode_regfile_tb.sv
module mode_regfile_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  mode;
  logic [3:0]  rdIdxA, rdIdxB, wrIdx;
  logic [31:0] rdDataA, rdDataB, wrData, pcWrData, pcOut;
  logic [31:0] spsrWrData, spsrRdData, cpsrWrData, cpsrOut;
  logic        wrEn, pcWrEn, spsrWrEn, cpsrWrEn;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [0:127];

  always #2 clk = ~clk;

  mode_regfile u_dut (
    .clk(clk), .rst(rst), .mode(mode),
    .rdIdxA(rdIdxA), .rdDataA(rdDataA), .rdIdxB(rdIdxB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .pcWrEn(pcWrEn), .pcWrData(pcWrData), .pcOut(pcOut),
    .spsrWrEn(spsrWrEn), .spsrWrData(spsrWrData), .spsrRdData(spsrRdData),
    .cpsrWrEn(cpsrWrEn), .cpsrWrData(cpsrWrData), .cpsrOut(cpsrOut)
  );

  // Storage key per (mode, index) derived from R1-style sharing rules.
  function automatic int keyOf(input int m, input int idx);
    if (idx < 8) return idx;                       // shared set
    if (m == 1) return 16 + idx;                   // fast-interrupt 8..14
    if (m >= 2 && m <= 5 && idx >= 13) return m * 16 + idx;
    return idx;                                    // user view (also 6, 7)
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wrEn = 0; pcWrEn = 0; spsrWrEn = 0; cpsrWrEn = 0;
  endtask

  task automatic writeReg(input int m, input int idx, input logic [31:0] v);
    @(negedge clk);
    mode = 3'(m); wrIdx = 4'(idx); wrData = v; wrEn = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic readCheck(input string req, input int m, input int ia,
                           input int ib);
    mode = 3'(m); rdIdxA = 4'(ia); rdIdxB = 4'(ib);
    #1;
    check(req, rdDataA, model[keyOf(m, ia)]);
    check(req, rdDataB, model[keyOf(m, ib)]);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    rst = 1; mode = 0; rdIdxA = 0; rdIdxB = 0; wrIdx = 0; wrData = 0;
    pcWrData = 0; spsrWrData = 0; cpsrWrData = 0;
    idle();
    for (int k = 0; k < 128; k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R9: reset state
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 15; i++) readCheck("R9 reset", m, i, 14 - i);
    check("R9 reset pc", pcOut, 0);
    check("R9 reset cpsr", cpsrOut, 0);

    // R1 R2 R3 R4: write every index in every defined mode, read all views
    for (int m = 0; m < 6; m++)
      for (int i = 0; i < 15; i++) begin
        logic [31:0] v;
        v = 32'hA000_0000 | (m << 8) | i;
        writeReg(m, i, v);
        model[keyOf(m, i)] = v;
      end
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 15; i++)
        readCheck("R1 R2 R3 R4 R10 banking", m, i, (i + 5) % 15);

    // R2: user write to 8..14 leaves fast-interrupt copies alone
    writeReg(0, 10, 32'h1111_0010);
    model[keyOf(0, 10)] = 32'h1111_0010;
    readCheck("R2 fiq private", 1, 10, 10);
    // R3: supervisor write to 9 is seen by user
    writeReg(3, 9, 32'h2222_0009);
    model[keyOf(3, 9)] = 32'h2222_0009;
    readCheck("R3 shared high", 0, 9, 9);
    // R4: mode 7 write lands in user copy of 14
    writeReg(7, 14, 32'h7777_000E);
    model[keyOf(7, 14)] = 32'h7777_000E;
    readCheck("R4 mode7 as user", 0, 14, 14);

    // R8: same-cycle read returns old, next cycle new
    @(negedge clk);
    mode = 1; rdIdxA = 3; rdIdxB = 12;
    wrIdx = 12; wrData = 32'h8888_000C; wrEn = 1;
    #1;
    check("R8 old value", rdDataB, model[keyOf(1, 12)]);
    @(negedge clk);
    idle();
    model[keyOf(1, 12)] = 32'h8888_000C;
    #1;
    check("R8 new value", rdDataB, 32'h8888_000C);

    // R5: pc path, port write to 15, and collision
    @(negedge clk); pcWrData = 32'h0000_1000; pcWrEn = 1;
    @(negedge clk); idle(); #1;
    check("R5 pc load", pcOut, 32'h0000_1000);
    rdIdxA = 15; #1;
    check("R5 pc via index", rdDataA, 32'h0000_1000);
    writeReg(2, 15, 32'h0000_2000); #1;
    check("R5 port write pc", pcOut, 32'h0000_2000);
    @(negedge clk);
    pcWrData = 32'h0000_3000; pcWrEn = 1;
    wrIdx = 15; wrData = 32'h0000_4000; wrEn = 1;
    @(negedge clk); idle(); #1;
    check("R5 pc path wins", pcOut, 32'h0000_3000);

    // R6: saved status per exception mode, user reads zero, ignores writes
    for (int m = 0; m < 8; m++) begin
      @(negedge clk); mode = 3'(m); spsrWrData = 32'h5000_0000 | m; spsrWrEn = 1;
      @(negedge clk); idle();
    end
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m); #1;
      check("R6 R4 saved status", spsrRdData,
            (m >= 1 && m <= 5) ? (32'h5000_0000 | m) : 32'h0);
    end

    // R7: current status shared across modes
    @(negedge clk); mode = 2; cpsrWrData = 32'hC000_00D3; cpsrWrEn = 1;
    @(negedge clk); idle();
    for (int m = 0; m < 8; m++) begin
      mode = 3'(m); #1;
      check("R7 cpsr shared", cpsrOut, 32'hC000_00D3);
    end
    writeReg(4, 1, 32'h0);
    model[1] = 32'h0;
    #1;
    check("R7 cpsr held", cpsrOut, 32'hC000_00D3);

    // R9: reset again clears everything
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int k = 0; k < 128; k++) model[k] = '0;
    for (int m = 0; m < 8; m++) begin
      for (int i = 0; i < 15; i++) readCheck("R9 re-reset", m, i, i);
      #1;
      check("R9 re-reset spsr", spsrRdData, 0);
    end
    check("R9 re-reset pc", pcOut, 0);
    check("R9 re-reset cpsr", cpsrOut, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule